// File: doc/BRIEF.md
# Stream Stall Timeout Timer

This block watches a stream producer that still has bytes to send. When the downstream sink stops accepting data while bytes are pending, the timer starts. It counts prescaled clock ticks up to a programmed limit. If the stall lasts that long, it sends a one-cycle timeout event to the interrupt logic. Any data movement, or the stall ending, stops the count.

The tick rate is the core clock divided by (prescale + 1). Arming captures the prescale and limit values and clears the prescaler phase, so later changes to those inputs only apply from the next arming. The timer is one-shot. After it fires it stays idle, even if the stall continues, until a new stall begins or a progress pulse re-arms it. A global enable gates everything. With enable low the timer never starts and cannot raise an event.

Top module: `stall_timeout_timer`

## Requirements
- R1: If a stall (enable high, pending high, sink_ready low) is first seen in cycle c and lasts with no progress pulse, timeout_o is high in cycle c + L'*(P+1) + 1. Here P is the prescale value and L' is the limit value, with the limit read as at least 1.
- R2: The timer arms only when all three stall conditions hold: enable high, pending high and sink_ready low. A sink that is ready, or no pending bytes, never produces an event.
- R3: A progress pulse during a stall stops the count. If the stall still holds in that cycle, the count restarts from the full limit with a fresh prescaler phase.
- R4: If sink_ready goes high or pending goes low, the timer stops. A later stall starts a new full-length count.
- R5: With enable low the timer does not arm. Dropping enable while the timer runs cancels it, and no event follows.
- R6: timeout_o is a single-cycle pulse. After it the timer stays idle, and a stall that continues raises no second pulse.
- R7: prescale_i and limit_i are captured at arming. Changes during a running count do not move the expiry cycle.
- R8: While rst_ni is low, timeout_o is low and the timer is idle.
- R9: A limit of 0 behaves like a limit of 1: expiry comes on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 12 | Tick divider; one tick every prescale_i+1 cycles |
| limit_i | input | 12 | Number of ticks before expiry |
| enable_i | input | 1 | Timer enable |
| pending_i | input | 1 | Producer still has bytes to send |
| sink_ready_i | input | 1 | Downstream sink accepts data |
| progress_i | input | 1 | One-cycle pulse on each data movement attempt |
| timeout_o | output | 1 | One-cycle stall-timeout event |

## Verification
The stall inputs are registered once, in the cycle the stall is seen, before arming takes effect. Each tick falls P+1 cycles after the previous one. The registered event appears one cycle after the final tick, so the bench expects the pulse exactly L'*(P+1)+1 clock edges after it applies a stall. The bench drives and samples only on the falling edge. It counts rising edges from the stall, or from the last restart, records the edge of the first pulse and the total number of pulses, and compares them with that formula. For a restart or an interrupted stall, the expected edge moves by the number of edges that passed before the new stall began.

// File: rtl/stall_timeout_pkg.sv
package stall_timeout_pkg;
  localparam int unsigned PRE_W_DEF = 12;
  localparam int unsigned CNT_W_DEF = 12;

  typedef enum logic [1:0] {
    TMR_IDLE    = 2'd0,
    TMR_ARM     = 2'd1,
    TMR_RUN     = 2'd2,
    TMR_EXPIRE  = 2'd3
  } tmr_evt_e;
endpackage

// File: rtl/stall_arm.sv
module stall_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic pending_i,
  input  logic sink_ready_i,
  input  logic progress_i,
  output logic stall_o,
  output logic arm_o
);
  logic stall_q;

  assign stall_o = enable_i & pending_i & ~sink_ready_i;
  // arm on stall onset, or re-arm after a movement attempt that left the stall in place
  assign arm_o   = stall_o & (~stall_q | progress_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_o;
  end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] phase_q;
  logic             wrap;

  assign wrap   = (phase_q == pre_q);
  assign tick_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (arm_i) begin
      pre_q   <= prescale_i;
      phase_q <= '0;
    end else if (run_i) begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/expiry_cnt.sv
module expiry_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] rem_q;

  // limit 0 and 1 both expire on the first tick
  assign last_o = (rem_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rem_q <= '0;
    else if (arm_i)            rem_q <= limit_i;
    else if (tick_i && !last_o) rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/stall_timeout_timer.sv
module stall_timeout_timer
  import stall_timeout_pkg::*;
#(
  parameter int unsigned PRE_W = PRE_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             enable_i,
  input  logic             pending_i,
  input  logic             sink_ready_i,
  input  logic             progress_i,
  output logic             timeout_o
);
  logic stall, arm, tick, last, expire;
  logic run_q, timeout_q;
  tmr_evt_e evt;

  stall_arm u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .pending_i    (pending_i),
    .sink_ready_i (sink_ready_i),
    .progress_i   (progress_i),
    .stall_o      (stall),
    .arm_o        (arm)
  );

  tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .run_i      (run_q),
    .prescale_i (prescale_i),
    .tick_o     (tick)
  );

  expiry_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .tick_i  (tick),
    .limit_i (limit_i),
    .last_o  (last)
  );

  assign expire = run_q & tick & last & stall & ~progress_i;

  always_comb begin
    if (arm)                  evt = TMR_ARM;
    else if (expire)          evt = TMR_EXPIRE;
    else if (run_q && stall)  evt = TMR_RUN;
    else                      evt = TMR_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      run_q     <= (evt == TMR_ARM) | (evt == TMR_RUN);
      timeout_q <= (evt == TMR_EXPIRE);
    end
  end

  assign timeout_o = timeout_q;
endmodule

// File: rtl/stall_timeout_timer_chk.sv
module stall_timeout_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic pending_i,
  input logic sink_ready_i,
  input logic progress_i,
  input logic timeout_o,
  input logic run_q
);
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  p_idle_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !run_q);

  p_needs_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(enable_i && pending_i && !sink_ready_i));

  p_enable_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!run_q && !timeout_o));

  p_progress_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    progress_i |=> !timeout_o);

  p_ready_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sink_ready_i || !pending_i) |=> (!run_q && !timeout_o));
endmodule

bind stall_timeout_timer stall_timeout_timer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .pending_i    (pending_i),
  .sink_ready_i (sink_ready_i),
  .progress_i   (progress_i),
  .timeout_o    (timeout_o),
  .run_q        (run_q)
);

// File: tb/stall_timeout_timer_tb.sv
module stall_timeout_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] prescale_i = '0;
  logic [11:0] limit_i = '0;
  logic        enable_i = 1'b0;
  logic        pending_i = 1'b0;
  logic        sink_ready_i = 1'b1;
  logic        progress_i = 1'b0;
  logic        timeout_o;

  int checks = 0, failures = 0;
  int n_edge = 0, first_seen = 0, pulses = 0;

  always #2 clk_i = ~clk_i;

  stall_timeout_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .prescale_i(prescale_i), .limit_i(limit_i),
    .enable_i(enable_i), .pending_i(pending_i), .sink_ready_i(sink_ready_i),
    .progress_i(progress_i), .timeout_o(timeout_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    n_edge++;
    if (timeout_o) begin
      pulses++;
      if (first_seen == 0) first_seen = n_edge;
    end
  endtask

  task automatic clr_obs();
    n_edge = 0; first_seen = 0; pulses = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic go_idle();
    sink_ready_i = 1'b1; pending_i = 1'b0; enable_i = 1'b1; progress_i = 1'b0;
    steps(3);
  endtask

  task automatic start_stall(input int p, input int l);
    prescale_i = 12'(p); limit_i = 12'(l);
    enable_i = 1'b1; pending_i = 1'b1; sink_ready_i = 1'b0;
    clr_obs();
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: reset holds output low even with a stall applied
    enable_i = 1'b1; pending_i = 1'b1; sink_ready_i = 1'b0;
    clr_obs();
    steps(6);
    check(pulses == 0 && timeout_o == 1'b0, "R8 reset", pulses, 0);
    sink_ready_i = 1'b1; pending_i = 1'b0;
    rst_ni = 1'b1;
    steps(2);

    // R1/R6/R9 sweep
    for (int p = 0; p < 4; p++) begin
      for (int l = 0; l < 5; l++) begin
        int lp, t;
        lp = (l == 0) ? 1 : l;
        t  = lp * (p + 1);
        start_stall(p, l);
        steps(t + 12);
        if (l == 0) check(first_seen == t + 1, "R9 limit0", first_seen, t + 1);
        else        check(first_seen == t + 1, "R1 expiry", first_seen, t + 1);
        check(pulses == 1, "R6 one-shot", pulses, 1);
        go_idle();
      end
    end

    // R3: progress restart (P=1,L=3,T=6)
    start_stall(1, 3);
    steps(3);
    progress_i = 1'b1; step(); progress_i = 1'b0;
    steps(16);
    check(first_seen == 10, "R3 restart", first_seen, 10);
    check(pulses == 1, "R3 pulses", pulses, 1);
    go_idle();

    // R3: progress ends the stall (pending drops with it)
    start_stall(1, 3);
    steps(3);
    progress_i = 1'b1; pending_i = 1'b0; step(); progress_i = 1'b0;
    steps(20);
    check(pulses == 0, "R3 stop", pulses, 0);
    go_idle();

    // R4: ready blip
    start_stall(1, 3);
    steps(3);
    sink_ready_i = 1'b1; step(); sink_ready_i = 1'b0;
    steps(16);
    check(first_seen == 11, "R4 ready", first_seen, 11);
    go_idle();

    // R4: pending blip
    start_stall(1, 3);
    steps(3);
    pending_i = 1'b0; step(); pending_i = 1'b1;
    steps(16);
    check(first_seen == 11, "R4 pending", first_seen, 11);
    go_idle();

    // R5: disabled stall
    start_stall(0, 2);
    enable_i = 1'b0;
    steps(30);
    check(pulses == 0, "R5 disabled", pulses, 0);
    go_idle();

    // R5: enable dropped mid-run
    start_stall(1, 3);
    steps(3);
    enable_i = 1'b0;
    steps(30);
    check(pulses == 0, "R5 drop", pulses, 0);
    go_idle();

    // R2: ready sink or no pending bytes never fire
    start_stall(0, 1);
    sink_ready_i = 1'b1;
    steps(20);
    check(pulses == 0, "R2 ready", pulses, 0);
    start_stall(0, 1);
    pending_i = 1'b0;
    steps(20);
    check(pulses == 0, "R2 nopend", pulses, 0);
    go_idle();

    // R7: config change while running ignored
    start_stall(1, 3);
    steps(2);
    limit_i = 12'd0; prescale_i = 12'd0;
    steps(18);
    check(first_seen == 7, "R7 latched", first_seen, 7);
    check(pulses == 1, "R7 pulses", pulses, 1);
    go_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule